// File: doc/BRIEF.md
# Segmented Block-Read Response Server

This block sits between a management controller and a two-wire host port. It holds one response message of up to 255 bytes and hands it out as a series of block reads of at most 32 data bytes each. A short message goes out in a single block. A long message is split into a first block that carries a start marker, then numbered continuation blocks, and finally a closing block whose index byte is 0xFF.

The host selects a block with one of three command codes. It can read block 0, step to the following block, or ask again for a block by its number. The chosen block is copied into a 33-byte staging area, which holds a count byte and 32 data bytes. The host then pulls the staging area one byte per read strobe.

The response side presents each message with an 8-bit tag and a declared length, then streams the bytes one per cycle. The block keeps only a message whose tag matches its expected sequence number, and cuts down any message that is too long.

Top module: `ssif_resp_segmenter`

## Requirements
- R1: After reset, exp_tag is 0, rd_data is 0x00, load_err is 0, and all 33 staging slots hold 0x00. No message is held, so any block command fails.
- R2: A pulse on rsp_start is accepted only when rsp_tag equals exp_tag. On acceptance, exp_tag increments modulo 256. A pulse with any other tag leaves exp_tag, the held message and its contents unchanged, and the bytes that follow it are dropped.
- R3: A held message of length L, with 1 ≤ L ≤ 32, has only block 0. Loading it writes slot 0 = L and slots 1..L = message bytes 0..L-1. Any other block number fails.
- R4: For a held message with L > 32, block 0 is staged as slot 0 = 32, slot 1 = 0x00, slot 2 = 0x01, and slots 3..32 = message bytes 0..29.
- R5: For L > 32, block n ≥ 1 starts at offset s = 30 + (n-1)*31 and carries d = min(31, L-s) bytes. Slot 0 = d+1. Slot 1 = n-1 if more bytes follow, otherwise 0xFF. Slots 2..d+1 hold the bytes.
- R6: Command 0x03 sets the block counter to 0 and loads. Command 0x09 adds 1 to the counter (modulo 256) and loads, and the counter moves even if the load fails. Command 0x0A sets the counter to cmd_arg and loads. Any other code has no effect.
- R7: A load fails when no message is held or when s ≥ L. A failed load raises load_err for exactly one cycle and leaves the staging slots and the read position unchanged. A successful load sets the read position to 0 and leaves any slots beyond the new block as they were.
- R8: Each rd_req returns the staging slot at the read position on rd_data in the next cycle, then advances the position. Once all 33 slots have been read, further reads return 0xFF.
- R9: A declared length above 255 is held as 255 bytes. Byte 2 is replaced by the completion code 0xC6, and the bytes past 255 are dropped.
- R10: An accepted rsp_start or a req_start resets the read position and the block counter to 0. A req_start also discards the held message. Either one takes priority over a command or a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | A new request is going out; discards the held message |
| rsp_start | input | 1 | Start of an incoming response |
| rsp_tag | input | 8 | Sequence tag of the incoming response |
| rsp_len | input | IN_LEN_W | Declared byte length of the incoming response |
| rsp_wr | input | 1 | Response byte strobe |
| rsp_byte | input | 8 | Response byte, in order from byte 0 |
| cmd_valid | input | 1 | Host block command strobe |
| cmd_code | input | 8 | Host command code (0x03, 0x09, 0x0A) |
| cmd_arg | input | 8 | Block number for the retry command |
| rd_req | input | 1 | Host byte read strobe |
| rd_data | output | 8 | Byte returned for the previous read strobe |
| load_err | output | 1 | One-cycle pulse after a failed block load |
| exp_tag | output | 8 | Sequence number the next response must carry |

## Verification
Three situations are the hardest to reach from the ports. The first is the wrap of the sequence number from 255 back to 0, which needs 256 accepted responses. The bench gets there cheaply by sending a run of zero-length responses, each tagged with the expected value. The second is the closing block of a truncated message, where the offset arithmetic and the forced completion code meet. Directed 300-byte responses reach it, as do random lengths that straddle the 32-byte and 255-byte limits. The third is that stale slots survive a shorter reload and a failed one. To show this, the bench reads the full 33-slot area, and past its end, after every kind of load.

// File: rtl/ssif_seg_pkg.sv
`timescale 1ns/1ps
package ssif_seg_pkg;

   // host command codes
   localparam logic [7:0] CMD_FIRST = 8'h03;
   localparam logic [7:0] CMD_NEXT  = 8'h09;
   localparam logic [7:0] CMD_RETRY = 8'h0A;

   // marker values inside staged blocks
   localparam logic [7:0] MARK_A    = 8'h00;
   localparam logic [7:0] MARK_B    = 8'h01;
   localparam logic [7:0] LAST_IDX  = 8'hFF;
   localparam logic [7:0] PAST_END  = 8'hFF;

   // message byte that carries the completion code
   localparam int TRUNC_POS = 2;

   typedef enum logic [1:0] {
      LAY_SHORT = 2'd0,
      LAY_FIRST = 2'd1,
      LAY_TAIL  = 2'd2
   } layout_e;

   typedef struct packed {
      logic       ok;
      layout_e    lay;
      logic [7:0] cnt;
      logic [7:0] idx;
   } plan_t;

endpackage

// File: rtl/ssif_rsp_store.sv
`timescale 1ns/1ps
module ssif_rsp_store
   import ssif_seg_pkg::*;
#(
   parameter int         MAX_LEN  = 255,
   parameter int         IN_LEN_W = 10,
   parameter logic [7:0] TRUNC_CC = 8'hC6,
   localparam int        LEN_W    = $clog2(MAX_LEN + 1)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_start,
   input  logic                rsp_start,
   input  logic [7:0]          rsp_tag,
   input  logic [IN_LEN_W-1:0] rsp_len,
   input  logic                rsp_wr,
   input  logic [7:0]          rsp_byte,
   output logic                accept,
   output logic [7:0]          exp_tag,
   output logic [LEN_W-1:0]    msg_len,
   output logic [7:0]          mem [MAX_LEN]
);

   logic [LEN_W-1:0] wr_idx;
   logic             wr_active;
   logic             trunc_q;
   logic             over;
   logic [LEN_W-1:0] new_len;
   logic             wr_fire;
   logic             cc_hit;
   logic [7:0]       wr_val;

   assign accept  = rsp_start && (rsp_tag == exp_tag);
   assign over    = rsp_len > IN_LEN_W'(MAX_LEN);
   assign new_len = over ? LEN_W'(MAX_LEN) : LEN_W'(rsp_len);
   assign wr_fire = rsp_wr && wr_active && !rsp_start && !req_start;

   generate
      if (MAX_LEN > TRUNC_POS) begin : g_cc
         assign cc_hit = trunc_q && (wr_idx == LEN_W'(TRUNC_POS));
      end else begin : g_no_cc
         assign cc_hit = 1'b0;
      end
   endgenerate

   assign wr_val = cc_hit ? TRUNC_CC : rsp_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_tag   <= '0;
         msg_len   <= '0;
         wr_idx    <= '0;
         wr_active <= 1'b0;
         trunc_q   <= 1'b0;
      end else if (accept) begin
         exp_tag   <= exp_tag + 8'd1;
         msg_len   <= new_len;
         wr_idx    <= '0;
         wr_active <= (new_len != '0);
         trunc_q   <= over;
      end else if (rsp_start) begin
         wr_active <= 1'b0;
      end else if (req_start) begin
         msg_len   <= '0;
         wr_active <= 1'b0;
      end else if (wr_fire) begin
         wr_idx <= wr_idx + 1'b1;
         if (wr_idx + 1'b1 >= msg_len) begin
            wr_active <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_fire) begin
         mem[wr_idx] <= wr_val;
      end
   end

endmodule

// File: rtl/ssif_blk_plan.sv
`timescale 1ns/1ps
module ssif_blk_plan
   import ssif_seg_pkg::*;
#(
   parameter int  MAX_LEN = 255,
   parameter int  CHUNK   = 32,
   localparam int LEN_W   = $clog2(MAX_LEN + 1),
   localparam int CW      = $clog2(CHUNK + 1),
   localparam int OFS_W   = 9 + CW
)(
   input  logic [LEN_W-1:0] msg_len,
   input  logic [7:0]       blk,
   output plan_t            plan,
   output logic [OFS_W-1:0] src_base,
   output logic [CW-1:0]    data_n
);

   localparam int FIRST_N = CHUNK - 2;
   localparam int MID_N   = CHUNK - 1;

   logic [OFS_W-1:0] ofs;
   logic [OFS_W-1:0] rem;
   logic [OFS_W-1:0] len_w;

   assign len_w = OFS_W'(msg_len);
   assign ofs   = OFS_W'(FIRST_N) + OFS_W'(blk - 8'd1) * OFS_W'(MID_N);
   assign rem   = len_w - ofs;

   always_comb begin
      plan.ok  = 1'b0;
      plan.lay = LAY_SHORT;
      plan.cnt = 8'd0;
      plan.idx = LAST_IDX;
      src_base = '0;
      data_n   = '0;
      if (msg_len == '0) begin
         plan.ok = 1'b0;
      end else if (len_w <= OFS_W'(CHUNK)) begin
         plan.ok  = (blk == 8'd0);
         plan.lay = LAY_SHORT;
         plan.cnt = 8'(msg_len);
         data_n   = CW'(msg_len);
      end else if (blk == 8'd0) begin
         plan.ok  = 1'b1;
         plan.lay = LAY_FIRST;
         plan.cnt = 8'(CHUNK);
         data_n   = CW'(FIRST_N);
      end else begin
         plan.ok  = (ofs < len_w);
         plan.lay = LAY_TAIL;
         src_base = ofs;
         if (rem > OFS_W'(MID_N)) begin
            data_n   = CW'(MID_N);
            plan.idx = blk - 8'd1;
            plan.cnt = 8'(MID_N + 1);
         end else begin
            data_n   = CW'(rem);
            plan.idx = LAST_IDX;
            plan.cnt = 8'(rem) + 8'd1;
         end
      end
   end

endmodule

// File: rtl/ssif_stage_buf.sv
`timescale 1ns/1ps
module ssif_stage_buf
   import ssif_seg_pkg::*;
#(
   parameter int  MAX_LEN = 255,
   parameter int  CHUNK   = 32,
   localparam int STAGE   = CHUNK + 1,
   localparam int CW      = $clog2(CHUNK + 1),
   localparam int OFS_W   = 9 + CW,
   localparam int PW      = $clog2(STAGE + 1),
   localparam int SW      = $clog2(STAGE),
   localparam int MW      = $clog2(MAX_LEN)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  layout_e          lay,
   input  logic [7:0]       cnt_byte,
   input  logic [7:0]       idx_byte,
   input  logic [OFS_W-1:0] src_base,
   input  logic [CW-1:0]    data_n,
   input  logic [7:0]       mem [MAX_LEN],
   input  logic             pos_clr,
   input  logic             rd_req,
   output logic [7:0]       rd_data,
   output logic [PW-1:0]    rd_pos
);

   logic [7:0] slot_q   [STAGE];
   logic [7:0] slot_nxt [STAGE];
   int         hdr_n;

   always_comb begin
      case (lay)
         LAY_FIRST: hdr_n = 3;
         LAY_TAIL:  hdr_n = 2;
         default:   hdr_n = 1;
      endcase
   end

   always_comb begin
      for (int i = 0; i < STAGE; i++) begin
         slot_nxt[i] = slot_q[i];
         if (i == 0) begin
            slot_nxt[i] = cnt_byte;
         end else if (i < hdr_n) begin
            if (lay == LAY_FIRST) begin
               slot_nxt[i] = (i == 1) ? MARK_A : MARK_B;
            end else begin
               slot_nxt[i] = idx_byte;
            end
         end else if (((i - hdr_n) < int'(data_n)) &&
                      ((int'(src_base) + i - hdr_n) < MAX_LEN)) begin
            slot_nxt[i] = mem[MW'(int'(src_base) + i - hdr_n)];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGE; i++) begin
            slot_q[i] <= 8'h00;
         end
      end else if (load) begin
         for (int i = 0; i < STAGE; i++) begin
            slot_q[i] <= slot_nxt[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= 8'h00;
         rd_pos  <= '0;
      end else begin
         if (rd_req) begin
            rd_data <= (rd_pos < PW'(STAGE)) ? slot_q[SW'(rd_pos)] : PAST_END;
         end
         if (pos_clr) begin
            rd_pos <= '0;
         end else if (rd_req && (rd_pos < PW'(STAGE))) begin
            rd_pos <= rd_pos + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ssif_resp_segmenter.sv
`timescale 1ns/1ps
module ssif_resp_segmenter
   import ssif_seg_pkg::*;
#(
   parameter int         MAX_LEN  = 255,
   parameter int         CHUNK    = 32,
   parameter int         IN_LEN_W = 10,
   parameter logic [7:0] TRUNC_CC = 8'hC6
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_start,
   input  logic                rsp_start,
   input  logic [7:0]          rsp_tag,
   input  logic [IN_LEN_W-1:0] rsp_len,
   input  logic                rsp_wr,
   input  logic [7:0]          rsp_byte,
   input  logic                cmd_valid,
   input  logic [7:0]          cmd_code,
   input  logic [7:0]          cmd_arg,
   input  logic                rd_req,
   output logic [7:0]          rd_data,
   output logic                load_err,
   output logic [7:0]          exp_tag
);

   localparam int STAGE = CHUNK + 1;
   localparam int LEN_W = $clog2(MAX_LEN + 1);
   localparam int CW    = $clog2(CHUNK + 1);
   localparam int OFS_W = 9 + CW;
   localparam int PW    = $clog2(STAGE + 1);

   generate
      if (CHUNK < 4 || CHUNK > 254) begin : g_bad_chunk
         $error("CHUNK must lie in 4..254");
      end
      if (MAX_LEN <= CHUNK) begin : g_bad_len
         $error("MAX_LEN must exceed CHUNK");
      end
      if (MAX_LEN >= (1 << IN_LEN_W)) begin : g_bad_in
         $error("IN_LEN_W too narrow for over-long responses");
      end
   endgenerate

   logic             accept;
   logic [LEN_W-1:0] msg_len;
   logic [7:0]       msg_mem [MAX_LEN];
   logic [7:0]       blk_cnt;
   logic [7:0]       blk_sel;
   logic             known;
   logic             session_clr;
   logic             cmd_fire;
   logic             load;
   plan_t            plan;
   logic [OFS_W-1:0] src_base;
   logic [CW-1:0]    data_n;
   logic [PW-1:0]    rd_pos;

   ssif_rsp_store #(
      .MAX_LEN (MAX_LEN),
      .IN_LEN_W(IN_LEN_W),
      .TRUNC_CC(TRUNC_CC)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_start(req_start),
      .rsp_start(rsp_start),
      .rsp_tag  (rsp_tag),
      .rsp_len  (rsp_len),
      .rsp_wr   (rsp_wr),
      .rsp_byte (rsp_byte),
      .accept   (accept),
      .exp_tag  (exp_tag),
      .msg_len  (msg_len),
      .mem      (msg_mem)
   );

   always_comb begin
      known   = 1'b1;
      blk_sel = blk_cnt;
      case (cmd_code)
         CMD_FIRST: blk_sel = 8'd0;
         CMD_NEXT:  blk_sel = blk_cnt + 8'd1;
         CMD_RETRY: blk_sel = cmd_arg;
         default:   known   = 1'b0;
      endcase
   end

   assign session_clr = accept || req_start;
   assign cmd_fire    = cmd_valid && known && !session_clr;

   ssif_blk_plan #(
      .MAX_LEN(MAX_LEN),
      .CHUNK  (CHUNK)
   ) u_plan (
      .msg_len (msg_len),
      .blk     (blk_sel),
      .plan    (plan),
      .src_base(src_base),
      .data_n  (data_n)
   );

   assign load = cmd_fire && plan.ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_cnt  <= 8'd0;
         load_err <= 1'b0;
      end else begin
         load_err <= cmd_fire && !plan.ok;
         if (session_clr) begin
            blk_cnt <= 8'd0;
         end else if (cmd_fire) begin
            blk_cnt <= blk_sel;
         end
      end
   end

   ssif_stage_buf #(
      .MAX_LEN(MAX_LEN),
      .CHUNK  (CHUNK)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .lay     (plan.lay),
      .cnt_byte(plan.cnt),
      .idx_byte(plan.idx),
      .src_base(src_base),
      .data_n  (data_n),
      .mem     (msg_mem),
      .pos_clr (session_clr || load),
      .rd_req  (rd_req),
      .rd_data (rd_data),
      .rd_pos  (rd_pos)
   );

endmodule

// File: rtl/ssif_seg_chk.sv
`timescale 1ns/1ps
module ssif_seg_chk
   import ssif_seg_pkg::*;
#(
   parameter int  CHUNK = 32,
   localparam int STAGE = CHUNK + 1,
   localparam int PW    = $clog2(STAGE + 1)
)(
   input logic          clk,
   input logic          rst_n,
   input logic          req_start,
   input logic          rsp_start,
   input logic [7:0]    rsp_tag,
   input logic          cmd_valid,
   input logic [7:0]    cmd_code,
   input logic          rd_req,
   input logic [7:0]    rd_data,
   input logic          load_err,
   input logic [7:0]    exp_tag,
   input logic [PW-1:0] rd_pos,
   input logic [7:0]    blk_cnt
);

   logic code_known;
   assign code_known = (cmd_code == CMD_FIRST) || (cmd_code == CMD_NEXT) ||
                       (cmd_code == CMD_RETRY);

   // R7: an error pulse only ever follows a command
   p_err_after_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |-> $past(cmd_valid));

   // R7: a failed load leaves the read position alone
   p_fail_keeps_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_err && !$past(rd_req)) |-> (rd_pos == $past(rd_pos)));

   // R6: unknown codes never report an error
   p_unknown_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !code_known) |=> !load_err);

   // R2: the sequence number moves only by one, on a matching tag
   p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_tag != $past(exp_tag)) |->
         ($past(rsp_start) && ($past(rsp_tag) == $past(exp_tag)) &&
          (exp_tag == $past(exp_tag) + 8'd1)));

   // R10: acceptance or a new request rewinds position and counter
   p_session_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((rsp_start && (rsp_tag == exp_tag)) || req_start) |=>
         ((rd_pos == '0) && (blk_cnt == 8'd0)));

   // R8: reads past the staging area return the filler byte
   p_overrun_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && (rd_pos >= PW'(STAGE))) |=> (rd_data == PAST_END));

   // R8: the read position never runs past one beyond the last slot
   p_pos_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pos <= PW'(STAGE));

endmodule

bind ssif_resp_segmenter ssif_seg_chk #(.CHUNK(CHUNK)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_start(req_start),
   .rsp_start(rsp_start),
   .rsp_tag  (rsp_tag),
   .cmd_valid(cmd_valid),
   .cmd_code (cmd_code),
   .rd_req   (rd_req),
   .rd_data  (rd_data),
   .load_err (load_err),
   .exp_tag  (exp_tag),
   .rd_pos   (rd_pos),
   .blk_cnt  (blk_cnt)
);

// File: tb/tb_ssif_resp_segmenter.sv
`timescale 1ns/1ps
module tb_ssif_resp_segmenter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_start = 1'b0;
   logic       rsp_start = 1'b0;
   logic [7:0] rsp_tag = 8'd0;
   logic [9:0] rsp_len = 10'd0;
   logic       rsp_wr = 1'b0;
   logic [7:0] rsp_byte = 8'd0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_code = 8'd0;
   logic [7:0] cmd_arg = 8'd0;
   logic       rd_req = 1'b0;
   logic [7:0] rd_data;
   logic       load_err;
   logic [7:0] exp_tag;

   always #2 clk = ~clk;

   ssif_resp_segmenter dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .rsp_start(rsp_start),
      .rsp_tag(rsp_tag), .rsp_len(rsp_len), .rsp_wr(rsp_wr), .rsp_byte(rsp_byte),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
      .rd_req(rd_req), .rd_data(rd_data), .load_err(load_err), .exp_tag(exp_tag)
   );

   int         nchk = 0;
   int         nerr = 0;
   logic [7:0] msg_m [255];
   int         len_m = 0;
   int         seq_m = 0;
   int         blk_m = 0;
   logic [7:0] st_m [33];
   int         pos_m = 0;

   task automatic check(string r, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual %0h expected %0h", r, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // staging model built from R3, R4, R5 and R7
   task automatic model_load(input int b, output bit ok);
      int s;
      int d;
      ok = 1'b0;
      if (len_m == 0) return;
      if (len_m <= 32) begin
         if (b != 0) return;
         st_m[0] = 8'(len_m);
         for (int j = 0; j < len_m; j++) st_m[j + 1] = msg_m[j];
      end else if (b == 0) begin
         st_m[0] = 8'd32;
         st_m[1] = 8'h00;
         st_m[2] = 8'h01;
         for (int j = 0; j < 30; j++) st_m[j + 3] = msg_m[j];
      end else begin
         s = 30 + (b - 1) * 31;
         if (s >= len_m) return;
         d = len_m - s;
         if (d > 31) begin
            d = 31;
            st_m[1] = 8'(b - 1);
         end else begin
            st_m[1] = 8'hFF;
         end
         st_m[0] = 8'(d + 1);
         for (int j = 0; j < d; j++) st_m[j + 2] = msg_m[s + j];
      end
      pos_m = 0;
      ok = 1'b1;
   endtask

   task automatic send_rsp(int tag, int len);
      bit acc;
      logic [7:0] b;
      rsp_start = 1'b1;
      rsp_tag   = 8'(tag);
      rsp_len   = 10'(len);
      tick();
      rsp_start = 1'b0;
      acc = (tag == seq_m);
      if (acc) begin
         seq_m = (seq_m + 1) % 256;
         len_m = (len > 255) ? 255 : len;
         blk_m = 0;
         pos_m = 0;
      end
      check("R2 exp_tag", exp_tag, seq_m);
      for (int j = 0; j < len; j++) begin
         b = 8'($urandom);
         rsp_wr   = 1'b1;
         rsp_byte = b;
         tick();
         if (acc && j < len_m) msg_m[j] = (len > 255 && j == 2) ? 8'hC6 : b;
      end
      rsp_wr = 1'b0;
   endtask

   task automatic do_cmd(input logic [7:0] code, input logic [7:0] arg,
                         input string r, output bit ok);
      int b;
      bit known;
      known = 1'b1;
      b = blk_m;
      if (code == 8'h03) b = 0;
      else if (code == 8'h09) b = (blk_m + 1) % 256;
      else if (code == 8'h0A) b = int'(arg);
      else known = 1'b0;
      cmd_valid = 1'b1;
      cmd_code  = code;
      cmd_arg   = arg;
      tick();
      cmd_valid = 1'b0;
      ok = 1'b0;
      if (known) begin
         blk_m = b;
         model_load(b, ok);
         check({r, " load_err"}, int'(load_err), ok ? 0 : 1);
      end else begin
         check({r, " unknown code load_err"}, int'(load_err), 0);
      end
   endtask

   task automatic rd_bytes(int n, string r);
      int e;
      for (int k = 0; k < n; k++) begin
         rd_req = 1'b1;
         tick();
         if (pos_m < 33) begin
            e = int'(st_m[pos_m]);
            pos_m++;
         end else begin
            e = 8'hFF;
         end
         check({r, " rd_data"}, int'(rd_data), e);
      end
      rd_req = 1'b0;
   endtask

   task automatic new_req();
      req_start = 1'b1;
      tick();
      req_start = 1'b0;
      len_m = 0;
      blk_m = 0;
      pos_m = 0;
   endtask

   task automatic walk_all(string r);
      bit ok;
      int guard;
      do_cmd(8'h03, 8'h00, r, ok);
      rd_bytes(34, r);
      guard = 0;
      while (ok && guard < 12) begin
         do_cmd(8'h09, 8'h00, r, ok);
         rd_bytes(ok ? 34 : 2, r);
         guard++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      bit ok;
      int op;
      void'($urandom(32'h5EED_0101));
      for (int i = 0; i < 33; i++) st_m[i] = 8'h00;
      for (int i = 0; i < 255; i++) msg_m[i] = 8'h00;
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      tick();

      // R1: reset state
      check("R1 exp_tag", exp_tag, 0);
      check("R1 rd_data", rd_data, 0);
      check("R1 load_err", load_err, 0);
      do_cmd(8'h03, 8'h00, "R1 no message", ok);
      tick();
      check("R7 single-cycle error", load_err, 0);
      rd_bytes(3, "R1 cleared staging");

      // R2: wrong tag ignored
      send_rsp(5, 20);
      do_cmd(8'h03, 8'h00, "R2 rejected response", ok);

      // R3: short message
      send_rsp(seq_m, 10);
      do_cmd(8'h03, 8'h00, "R3 short block", ok);
      rd_bytes(12, "R3 short data");
      do_cmd(8'h09, 8'h00, "R3 second block", ok);
      do_cmd(8'h0A, 8'h00, "R6 retry zero", ok);
      rd_bytes(36, "R8 overrun");
      rd_bytes(2, "R7 pos kept after fail");

      // R2: rejected bytes do not disturb the held message
      send_rsp(seq_m + 7, 10);
      do_cmd(8'h03, 8'h00, "R2 held intact", ok);
      rd_bytes(12, "R2 held data");

      // R6: unknown code
      rd_bytes(4, "R6 before unknown");
      do_cmd(8'h02, 8'h11, "R6", ok);
      rd_bytes(4, "R6 staging unchanged");

      // R4/R5: long message
      send_rsp(seq_m, 100);
      walk_all("R4 R5 long");
      do_cmd(8'h0A, 8'd2, "R6 retry two", ok);
      rd_bytes(34, "R5 retried block");
      do_cmd(8'h0A, 8'd4, "R5 beyond end", ok);

      // boundaries at 32 and 33
      send_rsp(seq_m, 32);
      walk_all("R3 len32");
      send_rsp(seq_m, 33);
      walk_all("R5 len33");
      send_rsp(seq_m, 61);
      walk_all("R5 len61");

      // R9: truncation
      send_rsp(seq_m, 300);
      walk_all("R9 truncated");
      do_cmd(8'h0A, 8'd8, "R9 last block", ok);
      rd_bytes(34, "R9 last data");

      // R10: accept and new request rewind
      rd_bytes(3, "R10 pre");
      send_rsp(seq_m, 40);
      rd_bytes(2, "R10 pos rewound on accept");
      do_cmd(8'h09, 8'h00, "R10 counter rewound", ok);
      rd_bytes(5, "R10 block1");
      new_req();
      rd_bytes(2, "R10 pos rewound on request");
      do_cmd(8'h03, 8'h00, "R10 message discarded", ok);

      // R2: zero-length and wrap of sequence number
      for (int i = 0; i < 256; i++) send_rsp(seq_m, 0);
      do_cmd(8'h03, 8'h00, "R7 empty message", ok);

      // random mix
      for (int it = 0; it < 40; it++) begin
         if ($urandom_range(0, 3) == 0) send_rsp((seq_m + 1) % 256, $urandom_range(0, 300));
         else send_rsp(seq_m, $urandom_range(0, 300));
         for (int k = 0; k < 8; k++) begin
            op = $urandom_range(0, 9);
            if (op < 2) do_cmd(8'h03, 8'h00, "R6 rand first", ok);
            else if (op < 5) do_cmd(8'h09, 8'h00, "R6 rand next", ok);
            else if (op < 6) do_cmd(8'h0A, 8'($urandom_range(0, 10)), "R6 rand retry", ok);
            else if (op < 9) rd_bytes($urandom_range(1, 36), "R8 rand read");
            else if ($urandom_range(0, 1) == 0) do_cmd(8'h55, 8'h00, "R6 rand unknown", ok);
            else new_req();
         end
      end

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule